// File: doc/BRIEF.md
# Self-Routing Four-Stage Binary Switch Fabric

This block moves up to sixteen requests per cycle from sixteen source lanes to sixteen destination lanes through four stages of 2x2 switching elements. Each source presents a valid bit, a 4-bit destination tag and a payload word. Stage k looks at one destination digit, and the element it uses is fixed by coordinate replacement. A lane number is read as the coordinate tuple (bit0, bit1, bit2, bit3). Entering stage k, a request sits on the lane whose low k-1 coordinates are already destination digits and whose upper coordinates are still source digits. The stage swaps coordinate k for destination digit k. After the last stage the lane number equals the destination.

Only one path exists for each source/destination pair. Two requests that need the same link therefore collide. The element resolves this at once: the request on its lower port wins, and the other request is discarded. Each stage is registered. Every injected request leaves the fabric after exactly four cycles, either delivered on its destination lane or reported through a per-source blocked flag. A new set of requests can be presented every cycle.

Top module: `bms_fabric`

## Requirements
- R1: While reset is high, and on the cycle after reset is sampled, every output valid bit and every blocked flag is zero.
- R2: A request sampled at clock edge t appears on the outputs right after edge t+3, with its payload word unchanged.
- R3: Lane numbers map to coordinates with bit 0 as the first coordinate. A lone request from source s tagged d appears on output lane d, for all 256 (s, d) pairs.
- R4: For each delivered request, the output source field on its lane gives the index of the source lane that injected it.
- R5: Stage k pairs the two lanes that differ only in coordinate k, and sends each request to the lane whose coordinate k equals destination digit k. Requests whose paths share no link, such as the identity mapping and the bitwise complement mapping, are all delivered in the same cycle.
- R6: When two requests in one element want the same output, the one on the port with coordinate k equal to 0 wins. The loser is dropped and its source's blocked flag is high in the cycle its delivery would have appeared. Every injected request ends up either delivered or flagged, never both.
- R7: A source whose valid bit is low creates no output traffic, whatever its tag and payload hold.
- R8: Sets of requests presented on consecutive cycles are handled independently and do not interfere with each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 16 | Per-source request valid |
| in_dst | input | 64 | Per-source destination tag, 4 bits per source, source s at bits [4s+3:4s] |
| in_dat | input | 128 | Per-source payload, 8 bits per source |
| out_vld | output | 16 | Per-destination delivery valid |
| out_src | output | 64 | Source index of the delivered request, 4 bits per lane |
| out_dat | output | 128 | Delivered payload, 8 bits per lane |
| out_blk | output | 16 | Per-source blocked flag, aligned with delivery timing |

## Verification
The checker assumes every input is at a known level on each sampled edge. It also assumes the valid bits alone decide which tags count, so garbage tags and payloads on idle sources are legal and must be ignored. The stimulus always drives all 16 tag and payload fields with defined values, and fills idle sources with random data to test that assumption. Collisions come both from hand-picked source pairs that meet at stages 1, 2 and 4, and from random back-to-back traffic. The expected frames for that traffic come from a bench model of link occupancy.

// File: rtl/bms_pkg.sv
package bms_pkg;
  // Lane that carries port bit_v of element elem in the stage that resolves
  // coordinate pos: insert bit_v into the element index at position pos.
  function automatic int lane_of(int elem, int pos, int bit_v);
    return ((elem >> pos) << (pos + 1)) | (elem & ((1 << pos) - 1)) | (bit_v << pos);
  endfunction
endpackage

// File: rtl/bms_cell.sv
module bms_cell #(
  parameter int NDIG = 4,
  parameter int DW   = 8
) (
  input  logic                      a_vld,
  input  logic [NDIG-1:0]           a_tag,
  input  logic [NDIG-1:0]           a_src,
  input  logic [DW-1:0]             a_dat,
  input  logic                      b_vld,
  input  logic [NDIG-1:0]           b_tag,
  input  logic [NDIG-1:0]           b_src,
  input  logic [DW-1:0]             b_dat,
  output logic [1:0]                o_vld,
  output logic [1:0][NDIG-1:0]      o_tag,
  output logic [1:0][NDIG-1:0]      o_src,
  output logic [1:0][DW-1:0]        o_dat,
  output logic                      b_lost
);
  // Port a (coordinate 0) has fixed priority over port b.
  always_comb begin
    b_lost = a_vld && b_vld && (a_tag[0] == b_tag[0]);
    for (int c = 0; c < 2; c++) begin
      if (a_vld && (a_tag[0] == c[0])) begin
        o_vld[c] = 1'b1;
        o_tag[c] = a_tag >> 1;
        o_src[c] = a_src;
        o_dat[c] = a_dat;
      end else if (b_vld && (b_tag[0] == c[0])) begin
        o_vld[c] = 1'b1;
        o_tag[c] = b_tag >> 1;
        o_src[c] = b_src;
        o_dat[c] = b_dat;
      end else begin
        o_vld[c] = 1'b0;
        o_tag[c] = '0;
        o_src[c] = '0;
        o_dat[c] = '0;
      end
    end
  end
endmodule

// File: rtl/bms_stage.sv
module bms_stage #(
  parameter int NDIG = 4,
  parameter int DW   = 8,
  parameter int SIDX = 0,
  localparam int N   = 1 << NDIG
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N-1:0]           i_vld,
  input  logic [N-1:0][NDIG-1:0] i_tag,
  input  logic [N-1:0][NDIG-1:0] i_src,
  input  logic [N-1:0][DW-1:0]   i_dat,
  input  logic [N-1:0]           i_drp,
  output logic [N-1:0]           o_vld,
  output logic [N-1:0][NDIG-1:0] o_tag,
  output logic [N-1:0][NDIG-1:0] o_src,
  output logic [N-1:0][DW-1:0]   o_dat,
  output logic [N-1:0]           o_drp
);
  localparam int NB = N / 2;

  logic [NB-1:0]           lost;
  logic [NB-1:0][NDIG-1:0] lsrc;
  logic [N-1:0]            n_vld;
  logic [N-1:0][NDIG-1:0]  n_tag;
  logic [N-1:0][NDIG-1:0]  n_src;
  logic [N-1:0][DW-1:0]    n_dat;
  logic [N-1:0]            n_drp;

  for (genvar e = 0; e < NB; e++) begin : g_cell
    localparam int LO = bms_pkg::lane_of(e, SIDX, 0);
    localparam int HI = bms_pkg::lane_of(e, SIDX, 1);
    logic [1:0]           ov;
    logic [1:0][NDIG-1:0] ot;
    logic [1:0][NDIG-1:0] os;
    logic [1:0][DW-1:0]   od;

    bms_cell #(.NDIG(NDIG), .DW(DW)) u_cell (
      .a_vld (i_vld[LO]), .a_tag(i_tag[LO]), .a_src(i_src[LO]), .a_dat(i_dat[LO]),
      .b_vld (i_vld[HI]), .b_tag(i_tag[HI]), .b_src(i_src[HI]), .b_dat(i_dat[HI]),
      .o_vld (ov), .o_tag(ot), .o_src(os), .o_dat(od),
      .b_lost(lost[e])
    );

    assign lsrc[e]   = i_src[HI];
    assign n_vld[LO] = ov[0];
    assign n_vld[HI] = ov[1];
    assign n_tag[LO] = ot[0];
    assign n_tag[HI] = ot[1];
    assign n_src[LO] = os[0];
    assign n_src[HI] = os[1];
    assign n_dat[LO] = od[0];
    assign n_dat[HI] = od[1];
  end

  // Accumulate per-source drop marks so they leave with the final stage.
  always_comb begin
    n_drp = i_drp;
    for (int e = 0; e < NB; e++) begin
      if (lost[e]) n_drp[lsrc[e]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      o_vld <= '0;
      o_drp <= '0;
    end else begin
      o_vld <= n_vld;
      o_drp <= n_drp;
    end
    o_tag <= n_tag;
    o_src <= n_src;
    o_dat <= n_dat;
  end
endmodule

// File: rtl/bms_fabric.sv
module bms_fabric #(
  parameter int NDIG = 4,
  parameter int DW   = 8,
  localparam int N   = 1 << NDIG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      in_vld,
  input  logic [N*NDIG-1:0] in_dst,
  input  logic [N*DW-1:0]   in_dat,
  output logic [N-1:0]      out_vld,
  output logic [N*NDIG-1:0] out_src,
  output logic [N*DW-1:0]   out_dat,
  output logic [N-1:0]      out_blk
);
  logic [N-1:0]           vld_p [NDIG+1];
  logic [N-1:0][NDIG-1:0] tag_p [NDIG+1];
  logic [N-1:0][NDIG-1:0] src_p [NDIG+1];
  logic [N-1:0][DW-1:0]   dat_p [NDIG+1];
  logic [N-1:0]           drp_p [NDIG+1];

  assign vld_p[0] = in_vld;
  assign tag_p[0] = in_dst;
  assign dat_p[0] = in_dat;
  assign drp_p[0] = '0;

  for (genvar s = 0; s < N; s++) begin : g_sid
    assign src_p[0][s] = NDIG'(s);
  end

  for (genvar k = 0; k < NDIG; k++) begin : g_stage
    bms_stage #(.NDIG(NDIG), .DW(DW), .SIDX(k)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .i_vld(vld_p[k]),   .i_tag(tag_p[k]),   .i_src(src_p[k]),
      .i_dat(dat_p[k]),   .i_drp(drp_p[k]),
      .o_vld(vld_p[k+1]), .o_tag(tag_p[k+1]), .o_src(src_p[k+1]),
      .o_dat(dat_p[k+1]), .o_drp(drp_p[k+1])
    );
  end

  assign out_vld = vld_p[NDIG];
  assign out_src = src_p[NDIG];
  assign out_dat = dat_p[NDIG];
  assign out_blk = drp_p[NDIG];
endmodule

// File: rtl/bms_chk.sv
module bms_chk #(
  parameter int NDIG = 4,
  localparam int N   = 1 << NDIG
) (
  input logic              clk,
  input logic              rst,
  input logic [N-1:0]      in_vld,
  input logic [N*NDIG-1:0] in_dst,
  input logic [N-1:0]      out_vld,
  input logic [N-1:0]      out_blk
);
  logic [N-1:0] dreq;
  logic [N-1:0] vpipe [NDIG];
  logic [N-1:0] dpipe [NDIG];

  always_comb begin
    dreq = '0;
    for (int s = 0; s < N; s++) begin
      if (in_vld[s]) dreq[in_dst[s*NDIG +: NDIG]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NDIG; i++) begin
        vpipe[i] <= '0;
        dpipe[i] <= '0;
      end
    end else begin
      vpipe[0] <= in_vld;
      dpipe[0] <= dreq;
      for (int i = 1; i < NDIG; i++) begin
        vpipe[i] <= vpipe[i-1];
        dpipe[i] <= dpipe[i-1];
      end
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (out_vld == '0 && out_blk == '0)); // R1

  AST_DELIVER_OR_FLAG: assert property (@(posedge clk) disable iff (rst)
    ($countones(out_vld) + $countones(out_blk)) == $countones(vpipe[NDIG-1])); // R6

  AST_FLAG_FROM_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (out_blk & ~vpipe[NDIG-1]) == '0); // R6

  AST_ONLY_REQUESTED_DEST: assert property (@(posedge clk) disable iff (rst)
    (out_vld & ~dpipe[NDIG-1]) == '0); // R3
endmodule

bind bms_fabric bms_chk #(.NDIG(NDIG)) u_chk (
  .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst),
  .out_vld(out_vld), .out_blk(out_blk)
);

// File: tb/sim_bms_fabric.sv
`timescale 1ns/1ps
module sim_bms_fabric;
  localparam int NDIG = 4;
  localparam int DW   = 8;
  localparam int N    = 1 << NDIG;
  localparam int LAT  = NDIG;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [N-1:0]           in_vld;
  logic [N-1:0][NDIG-1:0] in_dst;
  logic [N-1:0][DW-1:0]   in_dat;
  logic [N-1:0]           out_vld;
  logic [N-1:0]           out_blk;
  logic [N*NDIG-1:0]      out_src;
  logic [N*DW-1:0]        out_dat;

  bms_fabric #(.NDIG(NDIG), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_dst(in_dst), .in_dat(in_dat),
    .out_vld(out_vld), .out_src(out_src), .out_dat(out_dat), .out_blk(out_blk)
  );

  typedef struct packed {
    logic [N-1:0]           vld;
    logic [N-1:0]           blk;
    logic [N-1:0][NDIG-1:0] src;
    logic [N-1:0][DW-1:0]   dat;
  } exp_t;

  exp_t  exp_q[$];
  string lbl_q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // Link-occupancy model: after stage k a request holds the lane whose
  // low k coordinates are its destination digits; the one arriving with
  // coordinate k = 1 loses a shared lane.
  function automatic exp_t model(logic [N-1:0] v, logic [N-1:0][NDIG-1:0] d,
                                 logic [N-1:0][DW-1:0] p);
    exp_t r;
    logic [N-1:0] alive;
    logic [N-1:0][NDIG-1:0] st;
    r = '0;
    alive = v;
    for (int s = 0; s < N; s++) st[s] = NDIG'(s);
    for (int k = 0; k < NDIG; k++) begin
      for (int s = 0; s < N; s++) if (alive[s]) st[s][k] = d[s][k];
      for (int s = 0; s < N; s++) begin
        if (alive[s] && s[k]) begin
          for (int t = 0; t < N; t++) begin
            if (alive[t] && !t[k] && st[t] == st[s]) begin
              alive[s] = 1'b0;
              r.blk[s] = 1'b1;
            end
          end
        end
      end
    end
    for (int s = 0; s < N; s++) begin
      if (alive[s]) begin
        r.vld[st[s]] = 1'b1;
        r.dat[st[s]] = p[s];
        r.src[st[s]] = NDIG'(s);
      end
    end
    return r;
  endfunction

  task automatic drive(input logic [N-1:0] v, input logic [N-1:0][NDIG-1:0] d,
                       input logic [N-1:0][DW-1:0] p, input string lbl);
    @(negedge clk);
    in_vld = v;
    in_dst = d;
    in_dat = p;
    exp_q.push_back(model(v, d, p));
    lbl_q.push_back(lbl);
  endtask

  task automatic fill_rand(output logic [N-1:0][NDIG-1:0] d, output logic [N-1:0][DW-1:0] p);
    for (int s = 0; s < N; s++) begin
      d[s] = NDIG'($urandom);
      p[s] = DW'($urandom);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  // Monitor: the item pushed LAT pushes ago is now at the outputs.
  initial begin
    exp_t  e;
    string l;
    bit    ok;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() >= LAT) begin
        e = exp_q.pop_front();
        l = lbl_q.pop_front();
        ok = (out_vld == e.vld) && (out_blk == e.blk);
        for (int i = 0; i < N; i++) begin
          if (e.vld[i] && (out_dat[i*DW +: DW] != e.dat[i] ||
                           out_src[i*NDIG +: NDIG] != e.src[i])) ok = 1'b0;
        end
        n_chk++;
        if (!ok) begin
          n_err++;
          $display("FAIL %s: vld=%h blk=%h src=%h dat=%h expected vld=%h blk=%h src=%h dat=%h",
                   l, out_vld, out_blk, out_src, out_dat, e.vld, e.blk, e.src, e.dat);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R8 watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [N-1:0]           v;
    logic [N-1:0][NDIG-1:0] d;
    logic [N-1:0][DW-1:0]   p;
    in_vld = '0;
    in_dst = '0;
    in_dat = '0;
    repeat (4) @(negedge clk);
    // R1: outputs quiet under reset
    n_chk += 2;
    if (out_vld != '0) begin
      n_err++;
      $display("FAIL R1 vld: actual=%h expected=0", out_vld);
    end
    if (out_blk != '0) begin
      n_err++;
      $display("FAIL R1 blk: actual=%h expected=0", out_blk);
    end
    rst = 1'b0;

    // R2 R3 R4: every lone source/destination pair, idle lanes hold garbage
    for (int s = 0; s < N; s++) begin
      for (int t = 0; t < N; t++) begin
        fill_rand(d, p);
        v = '0;
        v[s] = 1'b1;
        d[s] = NDIG'(t);
        p[s] = DW'(s * 16 + t);
        drive(v, d, p, "R2 R3 R4 single");
      end
    end

    // R5: full permutations with disjoint paths
    fill_rand(d, p);
    for (int s = 0; s < N; s++) d[s] = NDIG'(s);
    drive('1, d, p, "R5 identity");
    fill_rand(d, p);
    for (int s = 0; s < N; s++) d[s] = ~NDIG'(s);
    drive('1, d, p, "R5 complement");

    // R6: collisions at stage 1, 2 and 4
    fill_rand(d, p);
    v = '0; v[0] = 1'b1; v[1] = 1'b1; d[0] = 4'd0; d[1] = 4'd2;
    drive(v, d, p, "R6 stage1 clash");
    fill_rand(d, p);
    v = '0; v[0] = 1'b1; v[2] = 1'b1; d[0] = 4'd0; d[2] = 4'd4;
    drive(v, d, p, "R6 stage2 clash");
    fill_rand(d, p);
    v = '0; v[0] = 1'b1; v[8] = 1'b1; d[0] = 4'd5; d[8] = 4'd5;
    drive(v, d, p, "R6 stage4 clash");
    fill_rand(d, p);
    v = '0; v[5] = 1'b1; v[4] = 1'b1; d[5] = 4'd9; d[4] = 4'd11;
    drive(v, d, p, "R6 stage1 clash b");

    // R7: idle frames with garbage
    for (int i = 0; i < 4; i++) begin
      fill_rand(d, p);
      drive('0, d, p, "R7 idle");
    end

    // R8: random back-to-back traffic
    for (int i = 0; i < 300; i++) begin
      fill_rand(d, p);
      v = N'($urandom);
      drive(v, d, p, "R8 random");
    end

    for (int i = 0; i < LAT + 2; i++) begin
      fill_rand(d, p);
      drive('0, d, p, "R7 flush");
    end
    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule